// File: doc/BRIEF.md
# Signal-Level Dual-Rail Selector

This block is the digital decision logic for a switching audio output stage that can run from either of two supplies. It watches the magnitude of each signed PCM sample, offered with a sample strobe, and compares it with one of four programmable low-level thresholds. Audio that stays at or under the threshold keeps the stage on the low rail. Audio above it moves the stage to the high rail. A change of rail in either direction only happens after the requested rail has stayed the same for a programmable number of sample periods. A request that flips back before then restarts the wait.

Two supply readings arrive as millivolt codes, together with a 6-bit undervoltage threshold code. The headroom is bad when the high supply is less than 2.5 V above the low supply, or when it is under the decoded undervoltage level. While the headroom is bad, switching is disabled and the stage is locked onto the high rail from the next clock on. A sticky fault flag records the event until software clears it with a pulse.

The controller is a five-state machine. The states are `ST_LOW` (settled on the low rail), `ST_UP_WAIT` (counting qualifying samples before moving up), `ST_HIGH` (settled on the high rail), `ST_DN_WAIT` (counting quiet samples before moving down) and `ST_LOCK` (headroom fault, high rail forced). Its transitions are:

- **LOW→HIGH**: a loud sample arrives with a zero delay setting.
- **LOW→UP_WAIT**: a loud sample arrives with a non-zero delay setting.
- **UP_WAIT→HIGH**: the count is complete.
- **UP_WAIT→LOW**: a quiet sample interrupts the count.
- **HIGH→LOW**, **HIGH→DN_WAIT**, **DN_WAIT→LOW** and **DN_WAIT→HIGH**: the mirror images of the four above.
- **any→LOCK**: the headroom is bad.
- **LOCK→HIGH**: the headroom is good again.

Top module: `dual_rail_sel`

## Requirements
- R1: After reset `rail_hi`=0, `sw_enable`=1 and `hr_fault`=0.
- R2: A sample is loud when its absolute value is strictly greater than the threshold picked by `thr_code`. For 24-bit samples the thresholds are: code 0 → 7, code 1 → 70, code 2 → 705, code 3 → 2232 LSB. The most negative sample saturates to magnitude 2^23−1 and is therefore loud.
- R3: A sample whose magnitude is less than or equal to the threshold is quiet, and a run of quiet samples keeps `rail_hi`=0.
- R4: `dly_code` sets a delay D, with 0 → 0, 1 → 4, 2 → 8 and 3 → 16 sample periods. Starting on the low rail, `rail_hi` rises on the clock after the strobe of the (D+1)-th consecutive loud sample, and not before.
- R5: A quiet sample that arrives while the block is counting toward the high rail cancels the count. A further D+1 consecutive loud samples are then needed.
- R6: Starting on the high rail, `rail_hi` falls on the clock after the strobe of the (D+1)-th consecutive quiet sample, using the same D as R4.
- R7: The headroom is bad when `hi_mv` < `lo_mv` + 2500. `hi_mv` = `lo_mv` + 2500 exactly counts as good.
- R8: `uv_code` decodes to a level of 1753 + floor(code·21247/63) mV. This gives 1753 at code 0, 2427 at code 2 and 23000 at code 63. The headroom is bad when `hi_mv` is below that level.
- R9: In the clock after the headroom becomes bad, `rail_hi`=1 and `sw_enable`=0, from any state and with any count in progress.
- R10: When the headroom becomes good again, `sw_enable` returns to 1 on the next clock and `rail_hi` stays 1. The block can then fall to the low rail only through the delay rule of R6.
- R11: `hr_fault` is 1 in the clock after any cycle with bad headroom. It holds until a `flag_clr` pulse arrives in a cycle with good headroom. If the headroom is bad in the same cycle as `flag_clr`, the flag stays set.
- R12: While `smp_valid` is 0, `smp_data` is ignored and `rail_hi` does not change unless the headroom is bad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle sample strobe |
| smp_data | input | 24 | Signed PCM sample |
| thr_code | input | 2 | Loudness threshold select |
| dly_code | input | 2 | Switching delay select |
| uv_code | input | 6 | High-supply undervoltage threshold code |
| hi_mv | input | 16 | High supply reading, millivolts |
| lo_mv | input | 16 | Low supply reading, millivolts |
| flag_clr | input | 1 | Clear pulse for the sticky fault flag |
| rail_hi | output | 1 | 1 selects the high rail, 0 the low rail |
| sw_enable | output | 1 | 1 while amplitude-driven switching is allowed |
| hr_fault | output | 1 | Sticky headroom fault flag |

## Verification
Two pairs of functions can land on the same clock edge. In the first pair, a headroom fault arrives while a delay count is half done. The bench sends two loud samples under an 8-sample delay and then drops `hi_mv` one millivolt below the headroom limit. It expects the high rail and disabled switching on the very next clock, with no further samples. In the second pair, a `flag_clr` pulse coincides with a bad-headroom cycle. The bench expects the flag to survive that pulse, and to clear only when a second pulse arrives after the supplies have recovered.

// File: rtl/dual_rail_sel_pkg.sv
package dual_rail_sel_pkg;

    typedef enum logic [2:0] {
        ST_LOW     = 3'd0,
        ST_UP_WAIT = 3'd1,
        ST_HIGH    = 3'd2,
        ST_DN_WAIT = 3'd3,
        ST_LOCK    = 3'd4
    } rail_state_t;

    localparam int unsigned MAX_DLY = 16;
    localparam int unsigned CNT_W   = $clog2(MAX_DLY + 1);

    // Loudness thresholds, scaled from a 24-bit full-scale reference.
    function automatic int unsigned thr_lsb(input logic [1:0] code, input int unsigned w);
        int unsigned base;
        case (code)
            2'd0:    base = 7;
            2'd1:    base = 70;
            2'd2:    base = 705;
            default: base = 2232;
        endcase
        if (w >= 24) return base << (w - 24);
        else         return base >> (24 - w);
    endfunction

    // Delay in sample periods: 0, 4, 8, 16.
    function automatic logic [CNT_W-1:0] dly_len(input logic [1:0] code);
        case (code)
            2'd0:    return CNT_W'(0);
            2'd1:    return CNT_W'(4);
            2'd2:    return CNT_W'(8);
            default: return CNT_W'(16);
        endcase
    endfunction

    // Undervoltage level in millivolts, linear over 64 codes.
    function automatic int unsigned uv_level_mv(input logic [5:0] code);
        return 32'd1753 + (32'(code) * 32'd21247) / 32'd63;
    endfunction

endpackage

// File: rtl/level_detect.sv
module level_detect
    import dual_rail_sel_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 24
) (
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [1:0]          thr_code,
    output logic                loud
);
    localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};
    localparam logic [SAMPLE_W-1:0] MOST_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};

    logic [SAMPLE_W-1:0] mag;
    logic [SAMPLE_W-1:0] thr_val;

    always_comb begin
        if (smp_data == MOST_NEG)
            mag = MOST_POS;
        else if (smp_data[SAMPLE_W-1])
            mag = ~smp_data + SAMPLE_W'(1);
        else
            mag = smp_data;
        thr_val = SAMPLE_W'(thr_lsb(thr_code, SAMPLE_W));
        loud    = (mag > thr_val);
    end
endmodule

// File: rtl/headroom_chk.sv
module headroom_chk
    import dual_rail_sel_pkg::*;
#(
    parameter int unsigned MV_W        = 16,
    parameter int unsigned HEADROOM_MV = 2500
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [MV_W-1:0] hi_mv,
    input  logic [MV_W-1:0] lo_mv,
    input  logic [5:0]      uv_code,
    input  logic            flag_clr,
    output logic            hr_bad,
    output logic            fault_q
);
    localparam int unsigned EXT_W = MV_W + 1;

    logic [EXT_W-1:0] lo_plus;
    logic [EXT_W-1:0] uv_ext;

    always_comb begin
        lo_plus = {1'b0, lo_mv} + EXT_W'(HEADROOM_MV);
        uv_ext  = EXT_W'(uv_level_mv(uv_code));
        hr_bad  = ({1'b0, hi_mv} < lo_plus) || ({1'b0, hi_mv} < uv_ext);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            fault_q <= 1'b0;
        else if (hr_bad)
            fault_q <= 1'b1;
        else if (flag_clr)
            fault_q <= 1'b0;
    end

    p_fault_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hr_bad |=> fault_q);

    p_fault_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !flag_clr) |=> fault_q);
endmodule

// File: rtl/rail_fsm.sv
module rail_fsm
    import dual_rail_sel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_valid,
    input  logic       loud,
    input  logic [1:0] dly_code,
    input  logic       hr_bad,
    output logic       rail_hi,
    output logic       sw_enable
);
    rail_state_t      st, st_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [CNT_W-1:0] dly;

    always_comb begin
        dly     = dly_len(dly_code);
        st_nxt  = st;
        cnt_nxt = cnt;
        if (hr_bad) begin
            st_nxt  = ST_LOCK;
            cnt_nxt = '0;
        end else begin
            unique case (st)
                ST_LOCK: begin
                    st_nxt  = ST_HIGH;
                    cnt_nxt = '0;
                end
                ST_LOW: begin
                    if (smp_valid && loud) begin
                        if (dly == '0) st_nxt = ST_HIGH;
                        else begin
                            st_nxt  = ST_UP_WAIT;
                            cnt_nxt = CNT_W'(1);
                        end
                    end
                end
                ST_UP_WAIT: begin
                    if (smp_valid) begin
                        if (!loud) begin
                            st_nxt  = ST_LOW;
                            cnt_nxt = '0;
                        end else if (cnt >= dly) begin
                            st_nxt  = ST_HIGH;
                            cnt_nxt = '0;
                        end else begin
                            cnt_nxt = cnt + CNT_W'(1);
                        end
                    end
                end
                ST_HIGH: begin
                    if (smp_valid && !loud) begin
                        if (dly == '0) st_nxt = ST_LOW;
                        else begin
                            st_nxt  = ST_DN_WAIT;
                            cnt_nxt = CNT_W'(1);
                        end
                    end
                end
                ST_DN_WAIT: begin
                    if (smp_valid) begin
                        if (loud) begin
                            st_nxt  = ST_HIGH;
                            cnt_nxt = '0;
                        end else if (cnt >= dly) begin
                            st_nxt  = ST_LOW;
                            cnt_nxt = '0;
                        end else begin
                            cnt_nxt = cnt + CNT_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_LOW;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    always_comb begin
        rail_hi   = (st == ST_HIGH) || (st == ST_DN_WAIT) || (st == ST_LOCK);
        sw_enable = (st != ST_LOCK);
    end

    p_fault_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hr_bad |=> rail_hi);

    p_fault_nosw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hr_bad |=> !sw_enable);

    p_idle_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !hr_bad) |=> $stable(rail_hi));

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_UP_WAIT || st == ST_DN_WAIT) |-> (cnt != '0 && cnt <= CNT_W'(MAX_DLY)));
endmodule

// File: rtl/dual_rail_sel.sv
module dual_rail_sel
    import dual_rail_sel_pkg::*;
#(
    parameter int unsigned SAMPLE_W    = 24,
    parameter int unsigned MV_W        = 16,
    parameter int unsigned HEADROOM_MV = 2500
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [1:0]          thr_code,
    input  logic [1:0]          dly_code,
    input  logic [5:0]          uv_code,
    input  logic [MV_W-1:0]     hi_mv,
    input  logic [MV_W-1:0]     lo_mv,
    input  logic                flag_clr,
    output logic                rail_hi,
    output logic                sw_enable,
    output logic                hr_fault
);
    logic loud;
    logic hr_bad;

    level_detect #(.SAMPLE_W(SAMPLE_W)) u_level (
        .smp_data (smp_data),
        .thr_code (thr_code),
        .loud     (loud)
    );

    headroom_chk #(.MV_W(MV_W), .HEADROOM_MV(HEADROOM_MV)) u_head (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_mv    (hi_mv),
        .lo_mv    (lo_mv),
        .uv_code  (uv_code),
        .flag_clr (flag_clr),
        .hr_bad   (hr_bad),
        .fault_q  (hr_fault)
    );

    rail_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .loud      (loud),
        .dly_code  (dly_code),
        .hr_bad    (hr_bad),
        .rail_hi   (rail_hi),
        .sw_enable (sw_enable)
    );

    p_reset_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_hi) |-> ($past(smp_valid) || $past(hr_bad)));
endmodule

// File: tb/dual_rail_sel_bench.sv
`timescale 1ns/1ps
module dual_rail_sel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_data = '0;
    logic [1:0]  thr_code = 2'd3;
    logic [1:0]  dly_code = 2'd0;
    logic [5:0]  uv_code = 6'd2;
    logic [15:0] hi_mv = 16'd12000;
    logic [15:0] lo_mv = 16'd5000;
    logic        flag_clr = 1'b0;
    logic        rail_hi, sw_enable, hr_fault;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dual_rail_sel u_dual_rail_sel (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .thr_code(thr_code), .dly_code(dly_code), .uv_code(uv_code),
        .hi_mv(hi_mv), .lo_mv(lo_mv), .flag_clr(flag_clr),
        .rail_hi(rail_hi), .sw_enable(sw_enable), .hr_fault(hr_fault)
    );

    function automatic int exp_thr(input int c);
        case (c)
            0: return 7;
            1: return 70;
            2: return 705;
            default: return 2232;
        endcase
    endfunction

    function automatic int exp_dly(input int c);
        case (c)
            0: return 0;
            1: return 4;
            2: return 8;
            default: return 16;
        endcase
    endfunction

    function automatic int exp_uv(input int c);
        return 1753 + (c * 21247) / 63;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic send(input logic [23:0] s);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = s;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R1 rail", rail_hi, 1'b0);
        check("R1 sw", sw_enable, 1'b1);
        check("R1 fault", hr_fault, 1'b0);

        // Threshold sweep with zero delay: rail follows each sample.
        dly_code = 2'd0;
        for (int c = 0; c < 4; c++) begin
            thr_code = 2'(c);
            for (int k = 0; k < 4; k++) begin
                int m;
                case (k)
                    0: m = exp_thr(c) - 1;
                    1: m = exp_thr(c);
                    2: m = exp_thr(c) + 1;
                    default: m = 8388607;
                endcase
                for (int sg = 0; sg < 2; sg++) begin
                    int v;
                    v = (sg == 0) ? m : -m;
                    send(24'(v));
                    if (m > exp_thr(c)) check("R2 loud", rail_hi, 1'b1);
                    else                check("R3 quiet", rail_hi, 1'b0);
                end
            end
            send(24'h800000);
            check("R2 most negative", rail_hi, 1'b1);
            send(24'd0);
            check("R3 zero", rail_hi, 1'b0);
        end

        // R12: strobe low, loud data ignored.
        smp_data = 24'h400000;
        repeat (4) begin
            tick();
            check("R12 no strobe", rail_hi, 1'b0);
        end

        // Delay sweep, up then down.
        thr_code = 2'd1;
        for (int dc = 0; dc < 4; dc++) begin
            dly_code = 2'(dc);
            for (int k = 1; k <= exp_dly(dc) + 2; k++) begin
                send(24'd5000);
                check("R4 up delay", rail_hi, (k >= exp_dly(dc) + 1) ? 1'b1 : 1'b0);
            end
            for (int k = 1; k <= exp_dly(dc) + 2; k++) begin
                send(24'd3);
                check("R6 down delay", rail_hi, (k >= exp_dly(dc) + 1) ? 1'b0 : 1'b1);
            end
        end

        // R5: interrupted count restarts.
        dly_code = 2'd1;
        repeat (3) send(24'd5000);
        send(24'd0);
        check("R5 interrupted", rail_hi, 1'b0);
        for (int k = 1; k <= 5; k++) begin
            send(-24'sd5000);
            check("R5 restart", rail_hi, (k == 5) ? 1'b1 : 1'b0);
        end
        dly_code = 2'd0;
        send(24'd0);
        check("R6 back low", rail_hi, 1'b0);

        // Fault during pending count; set wins over clear.
        dly_code = 2'd2;
        send(24'd5000);
        send(24'd5000);
        check("R4 pending", rail_hi, 1'b0);
        hi_mv = lo_mv + 16'd2499;
        tick();
        check("R9 forced high", rail_hi, 1'b1);
        check("R9 switching off", sw_enable, 1'b0);
        check("R7 one below headroom", hr_fault, 1'b1);
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
        check("R11 set wins", hr_fault, 1'b1);
        send(24'd0);
        check("R9 locked", rail_hi, 1'b1);
        hi_mv = lo_mv + 16'd2500;
        tick();
        check("R10 sw back", sw_enable, 1'b1);
        check("R10 stays high", rail_hi, 1'b1);
        check("R11 sticky", hr_fault, 1'b1);
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
        check("R11 cleared", hr_fault, 1'b0);
        for (int k = 1; k <= 9; k++) begin
            send(24'd0);
            check("R10 delayed fall", rail_hi, (k == 9) ? 1'b0 : 1'b1);
        end

        // R8: undervoltage code sweep.
        lo_mv = 16'd0;
        for (int c = 0; c < 64; c++) begin
            int u;
            uv_code = 6'(c);
            u = exp_uv(c);
            hi_mv = 16'(u - 1);
            tick();
            tick();
            check("R8 below uv", sw_enable, 1'b0);
            hi_mv = 16'(u);
            tick();
            tick();
            check("R8 at uv", sw_enable, (u < 2500) ? 1'b0 : 1'b1);
        end
        hi_mv = 16'd12000;
        lo_mv = 16'd5000;
        uv_code = 6'd2;
        tick();
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
        check("R11 final clear", hr_fault, 1'b0);
        check("R10 final sw", sw_enable, 1'b1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule